// File: doc/BRIEF.md
# Cache snoop response controller

This block sits on the memory side of one private cache in a snooping bus system. Each cycle it may accept one snoop. It checks that snoop against the tag-lookup result for the local line and against the match signal from the pending writeback buffer. From these it decides four things. It decides whether the cache answers in place of memory, which it signals by driving the memory-inhibit output. It decides whether the line is reported as shared and how the local line state must change. It also decides whether a queued writeback must be dropped.

When the cache owns the line, it answers. It owns the line when it holds a dirty valid copy or when the line is waiting in the writeback buffer. An upgrade request to the owner gets a response with no data; read-type snoops get data. The response request leaves the block a fixed number of cycles after the decision flags. The buffer that supplied it is reported with the request.

The decision flags are registered, so they are visible in the cycle after the snoop is sampled. The response request goes through a pipeline of `HIT_LAT` stages after that register. Snoops may arrive back to back.

Top module: `snp_resp_ctrl`

## Requirements
- R1: A snoop is ignored when it is marked uncacheable or its command is a writeback (code 3). It is also ignored when `snp_valid` is low. An ignored snoop produces no inhibit, no shared indication, no line update, no discard, no error and no response.
- R2: The block asserts `mem_inhibit` and issues a response only when the command needs a response and the block owns the line. Commands 0 (shared read), 1 (exclusive read) and 2 (upgrade) need a response. The block owns the line on a tag hit with the valid bit (bit 2) and dirty bit (bit 0) set, or on a writeback-buffer hit.
- R3: A snoop that arrives with `snp_inhibit_in` high is never answered.
- R4: `resp_with_data` is set only for read commands (0 and 1). An upgrade response carries no data.
- R5: `snp_shared` is asserted when the snoop hits, and is not exclusive, and is not ignored. A hit means a valid tag line or a writeback-buffer match.
- R6: An invalidating snoop that hits a valid line strobes `line_wr_en` with new state 3'b000. The state bits are valid (bit 2), writable (bit 1) and dirty (bit 0).
- R7: On a writeback-buffer hit, an owner response is marked `resp_from_wbb`. An invalidating snoop also pulses `wbb_discard`.
- R8: The decision flags appear in the cycle after the snoop is sampled. The response request (`resp_valid` with `resp_addr` equal to the snoop address) appears `HIT_LAT` cycles after those flags.
- R9: A non-invalidating snoop that hits a valid line strobes `line_wr_en`. The new state equals the old state with only the writable bit cleared.
- R10: A snoop that misses both the tag array and the writeback buffer leaves every output deasserted.
- R11: `proto_err` is raised for a dirty valid hit while `snp_inhibit_in` is high. It is also raised for a hit by a snoop that is exclusive but not invalidating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | A snoop is presented this cycle |
| snp_cmd | input | 2 | 0 shared read, 1 exclusive read, 2 upgrade, 3 writeback |
| snp_addr | input | ADDR_W | Line address of the snoop |
| snp_uncached | input | 1 | Snoop is uncacheable |
| snp_excl | input | 1 | Snoop needs exclusive ownership |
| snp_inval | input | 1 | Snoop invalidates other copies |
| snp_inhibit_in | input | 1 | Another agent has already claimed the response |
| tag_hit | input | 1 | Tag lookup matched |
| tag_state | input | 3 | Local line state {valid, writable, dirty} |
| wbb_hit | input | 1 | Address matches the pending writeback buffer |
| mem_inhibit | output | 1 | This cache answers instead of memory |
| snp_shared | output | 1 | Line remains shared |
| line_wr_en | output | 1 | Strobe to update the local line state |
| line_state_nxt | output | 3 | New line state (zero when no strobe) |
| wbb_discard | output | 1 | Drop the pending writeback |
| proto_err | output | 1 | Protocol violation detected |
| resp_valid | output | 1 | Timed response request |
| resp_with_data | output | 1 | Response carries line data |
| resp_from_wbb | output | 1 | Response sourced from the writeback buffer |
| resp_addr | output | ADDR_W | Address of the response |

## Verification
Directed cases focus on an upgrade that hits a dirty owner. A design that still gates responses on reads would leave the upgrader without an answer, and one that attaches data would set `resp_with_data`. The bench also sends snoops that arrive with inhibit already claimed: a faulty design answers twice and never reports the error. Other cases send writeback-buffer hits, where a wrong design stays silent or keeps a writeback that an invalidation should drop, and uncacheable or writeback snoops that a wrong design lets change line state. Back-to-back random snoops check that every response lands exactly `HIT_LAT` cycles after its flags with the right address, so an off-by-one stage count shows up at once.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [1:0] {
      SNP_RD_SHARED = 2'd0,
      SNP_RD_EXCL   = 2'd1,
      SNP_UPGRADE   = 2'd2,
      SNP_WRBACK    = 2'd3
   } snp_cmd_e;

   typedef struct packed {
      logic valid;
      logic writable;
      logic dirty;
   } line_st_t;

   typedef struct packed {
      logic     inhibit;
      logic     shared;
      logic     wr_en;
      line_st_t new_st;
      logic     wb_drop;
      logic     perr;
      logic     resp;
      logic     resp_data;
      logic     resp_wbb;
   } snp_dec_t;

endpackage

// File: rtl/snp_classify.sv
module snp_classify
   import snp_pkg::*;
(
   input  logic     valid,
   input  snp_cmd_e cmd,
   input  logic     uncached,
   output logic     ignore,
   output logic     needs_resp,
   output logic     is_read
);

   always_comb begin
      ignore     = !valid || uncached || (cmd == SNP_WRBACK);
      needs_resp = 1'b0;
      is_read    = 1'b0;
      unique case (cmd)
         SNP_RD_SHARED, SNP_RD_EXCL: begin
            needs_resp = 1'b1;
            is_read    = 1'b1;
         end
         SNP_UPGRADE: needs_resp = 1'b1;
         default:     needs_resp = 1'b0;
      endcase
   end

endmodule

// File: rtl/snp_decide.sv
module snp_decide
   import snp_pkg::*;
(
   input  logic     ignore,
   input  logic     needs_resp,
   input  logic     is_read,
   input  logic     excl,
   input  logic     inval,
   input  logic     inhibit_in,
   input  logic     tag_hit,
   input  line_st_t tag_state,
   input  logic     wbb_hit,
   output snp_dec_t dec
);

   logic line_valid;
   logic dirty_hit;
   logic any_hit;
   logic owner;

   always_comb begin
      line_valid = tag_hit && tag_state.valid;
      dirty_hit  = line_valid && tag_state.dirty;
      any_hit    = line_valid || wbb_hit;
      owner      = dirty_hit || wbb_hit;

      dec = '0;
      if (!ignore) begin
         dec.resp      = needs_resp && owner && !inhibit_in;
         dec.inhibit   = dec.resp;
         dec.resp_data = dec.resp && is_read;
         dec.resp_wbb  = dec.resp && wbb_hit;
         dec.shared    = any_hit && !excl;
         dec.wr_en     = line_valid;
         dec.wb_drop   = wbb_hit && inval;
         dec.perr      = (dirty_hit && inhibit_in) || (any_hit && excl && !inval);
         if (line_valid && !inval) begin
            dec.new_st          = tag_state;
            dec.new_st.writable = 1'b0;
         end
      end
   end

endmodule

// File: rtl/snp_resp_delay.sv
module snp_resp_delay #(
   parameter int ADDR_W = 32,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_data,
   input  logic              in_wbb,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic              out_data,
   output logic              out_wbb,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int PW = ADDR_W + 2;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("snp_resp_delay: LAT must be at least 1");
      end
      for (genvar g = 0; g < LAT; g++) begin : g_stage
         logic          sv;
         logic [PW-1:0] sp;
         if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  sv <= 1'b0;
                  sp <= '0;
               end else begin
                  sv <= in_valid;
                  sp <= in_valid ? {in_data, in_wbb, in_addr} : '0;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  sv <= 1'b0;
                  sp <= '0;
               end else begin
                  sv <= g_stage[g-1].sv;
                  sp <= g_stage[g-1].sp;
               end
            end
         end
      end
   endgenerate

   assign out_valid = g_stage[LAT-1].sv;
   assign out_data  = g_stage[LAT-1].sp[PW-1];
   assign out_wbb   = g_stage[LAT-1].sp[PW-2];
   assign out_addr  = g_stage[LAT-1].sp[ADDR_W-1:0];

   a_r8_payload_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == 1'b0 && out_wbb == 1'b0));

endmodule

// File: rtl/snp_resp_ctrl.sv
module snp_resp_ctrl
   import snp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int HIT_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_uncached,
   input  logic              snp_excl,
   input  logic              snp_inval,
   input  logic              snp_inhibit_in,
   input  logic              tag_hit,
   input  logic [2:0]        tag_state,
   input  logic              wbb_hit,
   output logic              mem_inhibit,
   output logic              snp_shared,
   output logic              line_wr_en,
   output logic [2:0]        line_state_nxt,
   output logic              wbb_discard,
   output logic              proto_err,
   output logic              resp_valid,
   output logic              resp_with_data,
   output logic              resp_from_wbb,
   output logic [ADDR_W-1:0] resp_addr
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("snp_resp_ctrl: ADDR_W must be positive");
      end
      if (HIT_LAT < 1 || HIT_LAT > 64) begin : g_bad_lat
         $error("snp_resp_ctrl: HIT_LAT out of range");
      end
   endgenerate

   logic              ignore, needs_resp, is_read;
   snp_dec_t          dec_d, dec_q;
   logic [ADDR_W-1:0] addr_q;

   snp_classify i_classify (
      .valid      (snp_valid),
      .cmd        (snp_cmd_e'(snp_cmd)),
      .uncached   (snp_uncached),
      .ignore     (ignore),
      .needs_resp (needs_resp),
      .is_read    (is_read)
   );

   snp_decide i_decide (
      .ignore     (ignore),
      .needs_resp (needs_resp),
      .is_read    (is_read),
      .excl       (snp_excl),
      .inval      (snp_inval),
      .inhibit_in (snp_inhibit_in),
      .tag_hit    (tag_hit),
      .tag_state  (line_st_t'(tag_state)),
      .wbb_hit    (wbb_hit),
      .dec        (dec_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= '0;
         addr_q <= '0;
      end else begin
         dec_q  <= dec_d;
         addr_q <= snp_addr;
      end
   end

   assign mem_inhibit    = dec_q.inhibit;
   assign snp_shared     = dec_q.shared;
   assign line_wr_en     = dec_q.wr_en;
   assign line_state_nxt = dec_q.new_st;
   assign wbb_discard    = dec_q.wb_drop;
   assign proto_err      = dec_q.perr;

   snp_resp_delay #(
      .ADDR_W (ADDR_W),
      .LAT    (HIT_LAT)
   ) i_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dec_q.resp),
      .in_data   (dec_q.resp_data),
      .in_wbb    (dec_q.resp_wbb),
      .in_addr   (addr_q),
      .out_valid (resp_valid),
      .out_data  (resp_with_data),
      .out_wbb   (resp_from_wbb),
      .out_addr  (resp_addr)
   );

   a_r1_uncached_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_uncached || snp_cmd == 2'd3) |=>
         (!mem_inhibit && !line_wr_en && !wbb_discard && !snp_shared && !proto_err));

   a_r3_no_double_answer: assert property (@(posedge clk) disable iff (!rst_n)
      snp_inhibit_in |=> !mem_inhibit);

   a_r4_data_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
      resp_with_data |-> resp_valid);

   a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_uncached && snp_cmd != 2'd3 && snp_inval && tag_hit && tag_state[2])
         |=> (line_wr_en && line_state_nxt == 3'b000));

   a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!tag_hit && !wbb_hit) |=> (!mem_inhibit && !snp_shared && !line_wr_en && !wbb_discard));

endmodule

// File: tb/test_snp_resp_ctrl.sv
module test_snp_resp_ctrl;

   localparam int ADDR_W  = 32;
   localparam int HIT_LAT = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              snp_valid, snp_uncached, snp_excl, snp_inval, snp_inhibit_in;
   logic [1:0]        snp_cmd;
   logic [ADDR_W-1:0] snp_addr;
   logic              tag_hit, wbb_hit;
   logic [2:0]        tag_state;
   logic              mem_inhibit, snp_shared, line_wr_en, wbb_discard, proto_err;
   logic [2:0]        line_state_nxt;
   logic              resp_valid, resp_with_data, resp_from_wbb;
   logic [ADDR_W-1:0] resp_addr;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   snp_resp_ctrl #(.ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT)) i_snp_resp_ctrl (.*);

   typedef struct packed {
      logic       ign, miss, inh_in, inval;
      logic       inhibit, shared, wr;
      logic [2:0] nst;
      logic       drop, perr, resp, rdata, rwbb;
      logic [ADDR_W-1:0] addr;
   } exp_t;

   exp_t ring [16];
   exp_t cur;

   function automatic exp_t model();
      exp_t e = '0;
      logic nr, rd, lv, dh, hit;
      e.ign    = !snp_valid || snp_uncached || snp_cmd == 2'd3;
      nr       = snp_cmd != 2'd3;
      rd       = snp_cmd < 2'd2;
      lv       = tag_hit && tag_state[2];
      dh       = lv && tag_state[0];
      hit      = lv || wbb_hit;
      e.miss   = !tag_hit && !wbb_hit;
      e.inh_in = snp_inhibit_in && dh && !e.ign;
      e.inval  = snp_inval;
      e.addr   = snp_addr;
      if (!e.ign) begin
         e.resp    = nr && (dh || wbb_hit) && !snp_inhibit_in;
         e.inhibit = e.resp;
         e.rdata   = e.resp && rd;
         e.rwbb    = e.resp && wbb_hit;
         e.shared  = hit && !snp_excl;
         e.wr      = lv;
         e.nst     = snp_inval ? 3'b000 : {tag_state[2], 1'b0, tag_state[0]};
         e.drop    = wbb_hit && snp_inval;
         e.perr    = (dh && snp_inhibit_in) || (hit && snp_excl && !snp_inval);
      end
      return e;
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] c, input logic unc,
                        input logic ex, input logic inv, input logic inh,
                        input logic th, input logic [2:0] st, input logic wh);
      snp_valid = v; snp_cmd = c; snp_uncached = unc; snp_excl = ex;
      snp_inval = inv; snp_inhibit_in = inh; tag_hit = th; tag_state = st;
      wbb_hit = wh; snp_addr = $urandom;
   endtask

   task automatic check_flags(input exp_t e);
      chk(mem_inhibit == e.inhibit, "R2", "mem_inhibit", mem_inhibit, e.inhibit);
      chk(snp_shared == e.shared, "R5", "shared", snp_shared, e.shared);
      chk(line_wr_en == e.wr, e.inval ? "R6" : "R9", "line_wr_en", line_wr_en, e.wr);
      if (e.wr)
         chk(line_state_nxt == e.nst, e.inval ? "R6" : "R9", "line_state", line_state_nxt, e.nst);
      chk(wbb_discard == e.drop, "R7", "wbb_discard", wbb_discard, e.drop);
      chk(proto_err == e.perr, "R11", "proto_err", proto_err, e.perr);
      if (e.ign)
         chk({mem_inhibit, snp_shared, line_wr_en, wbb_discard, proto_err} == 0,
             "R1", "ignored snoop outputs", {mem_inhibit, snp_shared, line_wr_en, wbb_discard, proto_err}, 0);
      if (e.inh_in)
         chk(!mem_inhibit, "R3", "answer despite inhibit", mem_inhibit, 0);
      if (e.miss)
         chk({mem_inhibit, snp_shared, line_wr_en, wbb_discard} == 0,
             "R10", "miss outputs", {mem_inhibit, snp_shared, line_wr_en, wbb_discard}, 0);
   endtask

   task automatic check_resp(input exp_t e);
      chk(resp_valid == e.resp, "R8", "resp_valid", resp_valid, e.resp);
      if (e.resp) begin
         chk(resp_addr == e.addr, "R8", "resp_addr", resp_addr, e.addr);
         chk(resp_with_data == e.rdata, "R4", "resp_with_data", resp_with_data, e.rdata);
         chk(resp_from_wbb == e.rwbb, "R7", "resp_from_wbb", resp_from_wbb, e.rwbb);
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed_0123);
      rst_n = 1'b0;
      drive(0, 0, 0, 0, 0, 0, 0, 3'b000, 0);
      for (int k = 0; k < 16; k++) ring[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk({mem_inhibit, snp_shared, line_wr_en, wbb_discard, proto_err, resp_valid} == 0,
          "R10", "reset outputs", {mem_inhibit, snp_shared, line_wr_en, wbb_discard, proto_err, resp_valid}, 0);

      for (int i = 0; i < 3000; i++) begin
         if (i > 0) begin
            check_flags(ring[(i-1) % 16]);
            if (i - 1 - HIT_LAT >= 0) check_resp(ring[(i-1-HIT_LAT) % 16]);
            else chk(!resp_valid, "R8", "early resp_valid", resp_valid, 0);
         end
         case (i)
            0:  drive(1, 0, 0, 0, 0, 0, 1, 3'b111, 0); // read shared hits dirty owner
            1:  drive(1, 2, 0, 1, 1, 0, 1, 3'b111, 0); // upgrade to owner: no data
            2:  drive(1, 2, 0, 1, 1, 0, 1, 3'b110, 0); // upgrade, clean line
            3:  drive(1, 1, 1, 1, 1, 0, 1, 3'b111, 0); // uncached: R1
            4:  drive(1, 3, 0, 0, 0, 0, 1, 3'b111, 0); // writeback cmd: R1
            5:  drive(1, 0, 0, 0, 0, 1, 1, 3'b101, 0); // inhibit already set: R3
            6:  drive(1, 1, 0, 1, 1, 0, 0, 3'b000, 1); // wbb owner, invalidated
            7:  drive(1, 2, 0, 1, 1, 0, 0, 3'b000, 1); // upgrade to wbb owner
            8:  drive(1, 0, 0, 0, 0, 0, 0, 3'b111, 0); // miss: R10
            9:  drive(1, 0, 0, 0, 0, 0, 0, 3'b000, 1); // wbb read shared
            10: drive(1, 1, 0, 1, 0, 0, 1, 3'b111, 0); // exclusive without invalidate
            11: drive(0, 0, 0, 0, 0, 0, 1, 3'b111, 1); // no snoop
            default: begin
               logic [1:0] c;
               logic ex, th;
               c  = 2'($urandom_range(0, 3));
               ex = (c != 2'd0) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
               th = $urandom_range(0, 9) < 6;
               drive($urandom_range(0, 19) != 0, c, $urandom_range(0, 9) == 0, ex,
                     ($urandom_range(0, 19) == 0) ? !ex : ex,
                     $urandom_range(0, 6) == 0, th, 3'($urandom),
                     !th && ($urandom_range(0, 4) == 0));
            end
         endcase
         cur = model();
         ring[i % 16] = cur;
         @(negedge clk);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule